// File: doc/BRIEF.md
# In-Order Issue Stall Sequencer

This block sits at the head of an in-order pipeline and decides, each clock cycle, whether the instruction presented there may issue. Upstream logic computes the hazard indications for that instruction: register read-after-write cycles left (or a flag saying the count is unknown), a busy execution resource, a memory-ordering conflict, a custom stall count and a write-back ordering delay. This block ranks those indications in a fixed priority and either grants issue in the same cycle or records a typed stall with its own cycle count.

While a stall is held, the block refuses all new candidates and counts the stall down once per cycle. When the count reaches zero, the held instruction is presented again ahead of any new work. In that cycle `retryActive` is high, and the hazard inputs are taken to describe the held instruction, whose tag is on `stallTag`. A retry either issues or records a fresh stall for the same tag. A pending multi-cycle carry-over from an earlier issue also blocks new candidates. The stall kind is exported so that performance counters can attribute lost cycles.

Top module: `issue_stall_seq`

## Requirements
- R1: While `rst` is high and after its release, `stallValid` is 0, `stallKind` is 0 (none), `stallCycles` is 0 and `issueGrant` and `candReady` are 0 during reset; whenever no stall is held, kind and cycles read 0.
- R2: When several hazards are present, the one that sets the stall is chosen in this order: register dependency (kind 1), resource busy (kind 2), memory ordering (kind 3), custom (kind 4), write-back ordering (kind 5).
- R3: A register hazard exists when `hazRawUnknown` is 1 or `hazRawCycles` is nonzero; it stalls for `hazRawCycles` cycles, or for exactly 1 cycle when `hazRawUnknown` is 1.
- R4: A busy resource stalls for exactly 1 cycle; a memory-ordering conflict stalls for exactly 1 cycle and counts only when `candIsMem` is 1, and is ignored otherwise.
- R5: The custom hazard stalls for `hazCustomCycles` cycles, and the write-back hazard for `hazWbDelay` cycles; a value of zero in either means no hazard.
- R6: A candidate with no hazard, presented while `candReady` is 1, is granted in the same cycle with `issueTag` equal to `candTag` and `issueRetry` 0, and no stall is recorded.
- R7: A stall of N cycles recorded in one cycle reads `stallValid`=1 and `stallCycles`=N-1 in the next cycle, and `stallCycles` then falls by one per cycle while nonzero, with the kind unchanged.
- R8: In a cycle where `stallValid` is 1 and `stallCycles` is 0, `retryActive` is 1. A hazard-free retry is granted with `issueTag` equal to the held tag and `issueRetry` 1, and the stall is gone in the next cycle. So a stall of N cycles is retried exactly N cycles after it was recorded.
- R9: A retry that meets a hazard records the new kind and count for the same held tag and is not granted.
- R10: While a stall is valid, `candReady` is 0 and a new candidate is neither granted nor recorded.
- R11: While `carryPending` is 1 and no stall is held, `candReady` is 0, no candidate is granted and no stall is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| candValid | input | 1 | A new instruction is presented |
| candTag | input | TAG_W | Tag of the new instruction |
| candIsMem | input | 1 | Presented instruction is a memory operation |
| carryPending | input | 1 | An earlier instruction still occupies issue slots |
| hazRawUnknown | input | 1 | Register dependency with unknown cycles left |
| hazRawCycles | input | CNT_W | Register dependency cycles left, 0 for none |
| hazResBusy | input | 1 | Needed execution resource is busy |
| hazMemNotReady | input | 1 | Memory ordering not yet satisfied |
| hazCustomCycles | input | CNT_W | Custom hazard cycles, 0 for none |
| hazWbDelay | input | CNT_W | Write-back ordering delay, 0 for none |
| candReady | output | 1 | A new candidate may be considered this cycle |
| retryActive | output | 1 | Held instruction is being retried; hazard inputs refer to it |
| issueGrant | output | 1 | An instruction issues this cycle |
| issueRetry | output | 1 | The issuing instruction is a retried one |
| issueTag | output | TAG_W | Tag of the issuing instruction |
| stallValid | output | 1 | A stall is held |
| stallKind | output | 3 | Reason of the held stall (0 none, 1 to 5 per R2) |
| stallCycles | output | CNT_W | Cycles left before the retry |
| stallTag | output | TAG_W | Tag of the held instruction |

## Verification
The grant, its tag, the retry flag and `candReady` are combinational and are due in the same cycle as the hazard inputs that decide them. The stall state (valid, kind, count) is registered and is due one cycle after the stimulus that records, counts or clears it. The driver applies every input set just after a falling edge and queues the values due for that cycle. The monitor compares them shortly before the next rising edge, so each check covers the grant of the current inputs together with the stall state left by the previous cycle. Count-down and retry timing is checked cycle by cycle, so a retry one cycle early or late shows as a miscompare.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [2:0] {
    STALL_NONE     = 3'd0,
    STALL_REGDEP   = 3'd1,
    STALL_RESOURCE = 3'd2,
    STALL_MEMORDER = 3'd3,
    STALL_CUSTOM   = 3'd4,
    STALL_WBORDER  = 3'd5
  } stallKind_e;

  localparam int NUM_HAZ_CLASSES = 5;

  // Strobes from control to the stall datapath
  typedef struct packed {
    logic load;       // record a new stall from the picked hazard
    logic clear;      // drop the held stall
    logic countDown;  // decrement the held count
    logic useHeld;    // present the held tag rather than the candidate tag
  } ctrlStrobes_t;

endpackage

// File: rtl/iss_hazard_pick.sv
module iss_hazard_pick
  import iss_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             rawUnknown,
  input  logic [CNT_W-1:0] rawCycles,
  input  logic             resBusy,
  input  logic             isMem,
  input  logic             memNotReady,
  input  logic [CNT_W-1:0] customCycles,
  input  logic [CNT_W-1:0] wbDelay,
  output logic             hazFound,
  output stallKind_e       hazKind,
  output logic [CNT_W-1:0] hazCycles
);

  localparam logic [CNT_W-1:0] ONE_CYCLE = CNT_W'(1);

  logic [NUM_HAZ_CLASSES-1:0] classHit;
  logic [CNT_W-1:0]           classCycles [NUM_HAZ_CLASSES];

  // Index 0 is the highest priority; kind code is index + 1
  assign classHit[0]    = rawUnknown || (rawCycles != '0);
  assign classCycles[0] = rawUnknown ? ONE_CYCLE : rawCycles;
  assign classHit[1]    = resBusy;
  assign classCycles[1] = ONE_CYCLE;
  assign classHit[2]    = isMem && memNotReady;
  assign classCycles[2] = ONE_CYCLE;
  assign classHit[3]    = (customCycles != '0);
  assign classCycles[3] = customCycles;
  assign classHit[4]    = (wbDelay != '0);
  assign classCycles[4] = wbDelay;

  // Walk from lowest to highest priority so the highest hit wins
  always_comb begin
    hazFound  = 1'b0;
    hazKind   = STALL_NONE;
    hazCycles = '0;
    for (int i = NUM_HAZ_CLASSES - 1; i >= 0; i--) begin
      if (classHit[i]) begin
        hazFound  = 1'b1;
        hazKind   = stallKind_e'(3'(i + 1));
        hazCycles = classCycles[i];
      end
    end
  end

endmodule

// File: rtl/iss_ctrl.sv
module iss_ctrl
  import iss_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         stallValid,
  input  logic         cntZero,
  input  logic         candValid,
  input  logic         carryPending,
  input  logic         hazFound,
  output ctrlStrobes_t strobes,
  output logic         issueGrant,
  output logic         issueRetry,
  output logic         candReady,
  output logic         retryActive
);

  logic holding;
  logic evalNew;
  logic evalAny;

  assign retryActive = !rst && stallValid && cntZero;
  assign holding     = stallValid && !cntZero;
  assign candReady   = !rst && !stallValid && !carryPending;
  assign evalNew     = candReady && candValid;
  assign evalAny     = retryActive || evalNew;

  assign issueGrant  = evalAny && !hazFound;
  assign issueRetry  = retryActive && !hazFound;

  assign strobes.load      = evalAny && hazFound;
  assign strobes.clear     = retryActive && !hazFound;
  assign strobes.countDown = !rst && holding;
  assign strobes.useHeld   = retryActive;

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (stallValid && !cntZero) |-> (!issueGrant && !candReady)) else $error("hold"); // R10

  AST_CARRY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (carryPending && !stallValid) |-> (!issueGrant && !strobes.load)) else $error("carry"); // R11

endmodule

// File: rtl/iss_dp.sv
module iss_dp
  import iss_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  stallKind_e       newKind,
  input  logic [CNT_W-1:0] newCycles,
  input  logic [TAG_W-1:0] candTag,
  output logic             stallValid,
  output stallKind_e       stallKind,
  output logic [CNT_W-1:0] stallCnt,
  output logic [TAG_W-1:0] stallTag,
  output logic             cntZero,
  output logic [TAG_W-1:0] presentTag
);

  assign presentTag = strobes.useHeld ? stallTag : candTag;
  assign cntZero    = (stallCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stallValid <= 1'b0;
      stallKind  <= STALL_NONE;
      stallCnt   <= '0;
      stallTag   <= '0;
    end else if (strobes.load) begin
      // The end-of-cycle decrement applies in the recording cycle too
      stallValid <= 1'b1;
      stallKind  <= newKind;
      stallCnt   <= newCycles - 1'b1;
      stallTag   <= presentTag;
    end else if (strobes.clear) begin
      stallValid <= 1'b0;
      stallKind  <= STALL_NONE;
      stallCnt   <= '0;
    end else if (strobes.countDown) begin
      stallCnt   <= stallCnt - 1'b1;
    end
  end

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !stallValid |-> (stallKind == STALL_NONE && stallCnt == '0)) else $error("idle"); // R1

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (stallValid && stallCnt != '0) |=>
      (stallValid && stallCnt == $past(stallCnt) - 1'b1 && stallKind == $past(stallKind))) else $error("count"); // R7

endmodule

// File: rtl/issue_stall_seq.sv
module issue_stall_seq
  import iss_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             candValid,
  input  logic [TAG_W-1:0] candTag,
  input  logic             candIsMem,
  input  logic             carryPending,
  input  logic             hazRawUnknown,
  input  logic [CNT_W-1:0] hazRawCycles,
  input  logic             hazResBusy,
  input  logic             hazMemNotReady,
  input  logic [CNT_W-1:0] hazCustomCycles,
  input  logic [CNT_W-1:0] hazWbDelay,
  output logic             candReady,
  output logic             retryActive,
  output logic             issueGrant,
  output logic             issueRetry,
  output logic [TAG_W-1:0] issueTag,
  output logic             stallValid,
  output logic [2:0]       stallKind,
  output logic [CNT_W-1:0] stallCycles,
  output logic [TAG_W-1:0] stallTag
);

  logic             hazFound;
  stallKind_e       hazKind;
  logic [CNT_W-1:0] hazCycles;
  ctrlStrobes_t     strobes;
  stallKind_e       heldKind;
  logic             cntZero;

  iss_hazard_pick #(.CNT_W(CNT_W)) u_pick (
    .rawUnknown   (hazRawUnknown),
    .rawCycles    (hazRawCycles),
    .resBusy      (hazResBusy),
    .isMem        (candIsMem),
    .memNotReady  (hazMemNotReady),
    .customCycles (hazCustomCycles),
    .wbDelay      (hazWbDelay),
    .hazFound     (hazFound),
    .hazKind      (hazKind),
    .hazCycles    (hazCycles)
  );

  iss_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .stallValid   (stallValid),
    .cntZero      (cntZero),
    .candValid    (candValid),
    .carryPending (carryPending),
    .hazFound     (hazFound),
    .strobes      (strobes),
    .issueGrant   (issueGrant),
    .issueRetry   (issueRetry),
    .candReady    (candReady),
    .retryActive  (retryActive)
  );

  iss_dp #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .newKind    (hazKind),
    .newCycles  (hazCycles),
    .candTag    (candTag),
    .stallValid (stallValid),
    .stallKind  (heldKind),
    .stallCnt   (stallCycles),
    .stallTag   (stallTag),
    .cntZero    (cntZero),
    .presentTag (issueTag)
  );

  assign stallKind = heldKind;

  AST_STALL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    hazFound |-> (hazCycles != '0)) else $error("zero stall"); // R3

  AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (issueGrant && issueRetry) |=> !stallValid) else $error("retry"); // R8

  AST_RETRY_SAME_TAG: assert property (@(posedge clk) disable iff (rst)
    (retryActive && !issueGrant) |=> (stallValid && stallTag == $past(stallTag))) else $error("retag"); // R9

endmodule

// File: tb/issue_stall_seq_bench.sv
module issue_stall_seq_bench;

  localparam int TAG_W = 6;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             candValid = 1'b0;
  logic [TAG_W-1:0] candTag = '0;
  logic             candIsMem = 1'b0;
  logic             carryPending = 1'b0;
  logic             hazRawUnknown = 1'b0;
  logic [CNT_W-1:0] hazRawCycles = '0;
  logic             hazResBusy = 1'b0;
  logic             hazMemNotReady = 1'b0;
  logic [CNT_W-1:0] hazCustomCycles = '0;
  logic [CNT_W-1:0] hazWbDelay = '0;
  logic             candReady, retryActive, issueGrant, issueRetry;
  logic [TAG_W-1:0] issueTag, stallTag;
  logic             stallValid;
  logic [2:0]       stallKind;
  logic [CNT_W-1:0] stallCycles;

  always #4 clk = ~clk;  // 125 MHz

  issue_stall_seq #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_issue_stall_seq (
    .clk(clk), .rst(rst), .candValid(candValid), .candTag(candTag),
    .candIsMem(candIsMem), .carryPending(carryPending),
    .hazRawUnknown(hazRawUnknown), .hazRawCycles(hazRawCycles),
    .hazResBusy(hazResBusy), .hazMemNotReady(hazMemNotReady),
    .hazCustomCycles(hazCustomCycles), .hazWbDelay(hazWbDelay),
    .candReady(candReady), .retryActive(retryActive),
    .issueGrant(issueGrant), .issueRetry(issueRetry), .issueTag(issueTag),
    .stallValid(stallValid), .stallKind(stallKind),
    .stallCycles(stallCycles), .stallTag(stallTag)
  );

  typedef struct {
    bit               grant;
    logic [TAG_W-1:0] tag;
    bit               retry;
    bit               ready;
    bit               sv;
    logic [2:0]       kind;
    logic [CNT_W-1:0] cyc;
    string            req;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  // Monitor: compare shortly before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        expItem_t e;
        bit bad;
        e = expQ.pop_front();
        nChecks++;
        bad = (issueGrant !== e.grant) || (candReady !== e.ready) ||
              (stallValid !== e.sv) || (stallKind !== e.kind) ||
              (stallCycles !== e.cyc) ||
              (e.grant && (issueTag !== e.tag || issueRetry !== e.retry));
        if (bad) begin
          nFails++;
          $display("FAIL %s: got grant=%0b tag=%0d retry=%0b ready=%0b sv=%0b kind=%0d cyc=%0d exp grant=%0b tag=%0d retry=%0b ready=%0b sv=%0b kind=%0d cyc=%0d",
                   e.req, issueGrant, issueTag, issueRetry, candReady, stallValid, stallKind, stallCycles,
                   e.grant, e.tag, e.retry, e.ready, e.sv, e.kind, e.cyc);
        end
      end
    end
  end

  task automatic clearIn();
    candValid = 0; candTag = '0; candIsMem = 0; carryPending = 0;
    hazRawUnknown = 0; hazRawCycles = '0; hazResBusy = 0; hazMemNotReady = 0;
    hazCustomCycles = '0; hazWbDelay = '0;
  endtask

  task automatic cand(input int tag);
    candValid = 1; candTag = TAG_W'(tag);
  endtask

  // Driver: inputs are already set at this falling edge; queue the expectation
  task automatic step(input bit g, input int tag, input bit rt, input bit rdy,
                      input bit sv, input int kind, input int cyc, input string req);
    expItem_t e;
    e.grant = g; e.tag = TAG_W'(tag); e.retry = rt; e.ready = rdy;
    e.sv = sv; e.kind = 3'(kind); e.cyc = CNT_W'(cyc); e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    clearIn();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog: got hung exp done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (2) @(negedge clk);
    // R1: reset state, candidate refused
    cand(5);
    step(0, 0, 0, 0, 0, 0, 0, "R1 reset");
    rst = 0;
    // R6: clean issue
    cand(1);
    step(1, 1, 0, 1, 0, 0, 0, "R6 clean issue");
    // R4: memory-ordering ignored for non-memory op
    cand(2); hazMemNotReady = 1;
    step(1, 2, 0, 1, 0, 0, 0, "R4 non-mem ignores ordering");
    // R2: register beats resource and custom; 3-cycle stall
    cand(3); hazRawCycles = 3; hazResBusy = 1; hazCustomCycles = 5;
    step(0, 0, 0, 1, 0, 0, 0, "R2 register first");
    cand(4);
    step(0, 0, 0, 0, 1, 1, 2, "R10 refused while held / R7");
    step(0, 0, 0, 0, 1, 1, 1, "R7 count down");
    // R8: retry of tag 3 after 3 cycles
    step(1, 3, 1, 0, 1, 1, 0, "R8 retry grant");
    // R3: unknown count gives 1 cycle
    cand(7); hazRawUnknown = 1; hazRawCycles = 9;
    step(0, 0, 0, 1, 0, 0, 0, "R3 unknown stall");
    // R9: retry stalls again on resource (beats custom)
    cand(9); hazResBusy = 1; hazCustomCycles = 4;
    step(0, 0, 0, 0, 1, 1, 0, "R3 unknown is one cycle / R9 restall");
    candIsMem = 1; hazMemNotReady = 1;
    step(0, 0, 0, 0, 1, 2, 0, "R4 resource one cycle");
    hazCustomCycles = 2; hazWbDelay = 6;
    step(0, 0, 0, 0, 1, 3, 0, "R4 mem ordering one cycle");
    step(0, 0, 0, 0, 1, 4, 1, "R5 custom count");
    hazWbDelay = 2;
    step(0, 0, 0, 0, 1, 4, 0, "R5 custom expiry");
    step(0, 0, 0, 0, 1, 5, 1, "R5 write-back delay");
    step(1, 7, 1, 0, 1, 5, 0, "R9 same tag kept");
    // R5: zero custom / wb means none
    cand(10);
    step(1, 10, 0, 1, 0, 0, 0, "R5 zero means none / R8 cleared");
    // R11: carry-over blocks and records nothing
    cand(11); carryPending = 1; hazRawCycles = 2;
    step(0, 0, 0, 0, 0, 0, 0, "R11 carry refuses");
    step(0, 0, 0, 1, 0, 0, 0, "R11 nothing recorded");
    // R4: resource stall is exactly one cycle
    cand(12); hazResBusy = 1;
    step(0, 0, 0, 1, 0, 0, 0, "R4 resource stall");
    step(1, 12, 1, 0, 1, 2, 0, "R4 resource retry");
    // R7: long register stall counts down to the retry
    cand(13); hazRawCycles = 15;
    step(0, 0, 0, 1, 0, 0, 0, "R3 long register stall");
    for (int c = 14; c >= 1; c--) begin
      cand(20);
      step(0, 0, 0, 0, 1, 1, c, "R7 long count");
    end
    step(1, 13, 1, 0, 1, 1, 0, "R8 long retry");
    // R2: memory ordering beats custom for a memory op
    cand(14); candIsMem = 1; hazMemNotReady = 1; hazCustomCycles = 3;
    step(0, 0, 0, 1, 0, 0, 0, "R2 mem before custom");
    step(1, 14, 1, 0, 1, 3, 0, "R2 mem kind");
    step(0, 0, 0, 1, 0, 0, 0, "R1 idle clean");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule